// File: doc/BRIEF.md
# UART Banked Register Decoder

This block is the host-facing register file of a 16550-style serial port. A host reaches it through a 3-bit address, separate one-cycle read and write strobes and a byte-wide data bus. Eight addresses cannot cover every register, so the decoder also looks at mode state it holds itself. The divisor-access bit in the line control register swaps the divisor latches in at the two lowest addresses. A key value written to the line control register opens an alternate storage bank. Two bits of an additional control register, reached through an index held in the scratch location, open an extended register and an indexed register set.

The block drives the baud divisor, the decoded frame-format fields, the modem-control lines and the interrupt-enable mask. It also sends registered one-cycle strobes to the receive FIFO (pop), the transmit FIFO (push) and the FIFO control logic. Status bytes and receive data come in from outside and are only muxed onto the read bus. Reads are combinational from the current address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `uart_regbank`

## Requirements
- R1: Writing any value other than 0xBF to address 3 stores it in the line control register. The outputs then show word_len_o = bit 1:0, stop2_o = bit 2, par_en_o = bit 3, par_even_o = bit 4, force_par_o = bit 5, brk_o = bit 6 and dlab_o = bit 7, and a read of address 3 returns the stored byte.
- R2: Writing 0xBF to address 3 sets dlab_o and leaves line control bits 6:0 unchanged. Addresses 2, 4, 5, 6 and 7 then reach five alternate storage bytes that keep their contents across bank changes. Any other value written to address 3 leaves the bank and is stored as given.
- R3: While dlab_o is 1, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. divisor_o changes only on such a write.
- R4: With dlab_o at 0 and no extended or indexed access enabled, reads return the following: address 0 gives rx_data_i, 1 gives the interrupt mask, 2 gives isr_i, 4 gives modem control, 5 gives lsr_i, 6 gives msr_i and 7 gives the scratch byte.
- R5: A read of address 0 with dlab_o at 0 gives exactly one rx_pop_o pulse in the following cycle. A write there gives one tx_push_o pulse in the following cycle, with wr_data_o holding the written byte. Divisor accesses give no strobe.
- R6: The interrupt mask keeps data bits 3:0 (bit 0 receive data, bit 1 transmit empty, bit 2 receive status, bit 3 modem status) on ier_o and reads back with bits 7:4 at zero. Modem control keeps bits 4:0 (dtr_o, rts_o, out1_o, out2_o, loop_o) and reads back with bits 7:5 at zero.
- R7: After reset, divisor_o is 0x0001 and the line control register, the interrupt mask, modem control, the scratch byte and every indexed register (the additional control register included) are 0.
- R8: Status locations are read-only. A write to address 6 while the extended register is disabled changes no state, and a read of address 5 returns lsr_i while indexed reads are disabled.
- R9: A write to address 5 with dlab_o at 0 outside the alternate bank goes to indexed register number (scratch byte). Index 0 is the additional control register. When its bit 6 is 1, a read of address 5 returns that indexed register, or 0 when the index is N_IDX or more.
- R10: When bit 7 of the additional control register is 1, address 6 reads and writes an extended register instead of the modem-status input.
- R11: A write to address 2 with dlab_o at 0 outside the alternate bank gives one fcr_wr_o pulse in the following cycle with wr_data_o holding the byte. It never coincides with tx_push_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| isr_i | input | 8 | Interrupt status byte |
| lsr_i | input | 8 | Line status byte |
| msr_i | input | 8 | Modem status byte |
| divisor_o | output | 16 | Baud divisor |
| dlab_o | output | 1 | Divisor access bit |
| word_len_o | output | 2 | Data length code |
| stop2_o | output | 1 | Extra stop bit |
| par_en_o | output | 1 | Parity enable |
| par_even_o | output | 1 | Even parity select |
| force_par_o | output | 1 | Forced parity |
| brk_o | output | 1 | Transmit break |
| ier_o | output | 4 | Interrupt enable mask |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| out1_o | output | 1 | User output 1 |
| out2_o | output | 1 | User output 2 |
| loop_o | output | 1 | Internal loopback enable |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| fcr_wr_o | output | 1 | FIFO control write strobe |
| wr_data_o | output | 8 | Byte carried with push or FIFO control strobe |

## Verification
Every line control value except the key is written and decoded, so each format field is checked against its own bit and the divisor bit against bit 7. Entering the key bank from a non-zero format shows that the format bits are kept. Reads at every address after bank exit, and alternate bytes that survive a re-entry, show that the two banks use separate storage. A divisor sweep with independent low and high bytes separates the two latches. An index sweep past N_IDX covers the out-of-range read. A status write made while the extended register is off is then compared with that register's reset value, which shows the write changed nothing.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int unsigned AW       = 3;
  localparam int unsigned DW       = 8;
  localparam int unsigned IER_W    = 4;
  localparam int unsigned MCR_W    = 5;
  localparam int unsigned ALT_N    = 5;
  localparam logic [DW-1:0] LCR_KEY = 8'hBF;

  typedef enum logic [3:0] {
    T_NONE, T_HOLD, T_DLL, T_DLM, T_IER, T_ISR_FCR, T_LCR, T_MCR,
    T_LSR, T_MSR, T_SPR, T_ALT, T_EXT, T_ICR
  } tgt_e;

  // alternate bank slot for addresses 2,4,5,6,7
  function automatic logic [2:0] alt_slot(input logic [AW-1:0] a);
    case (a)
      3'd2:    alt_slot = 3'd0;
      3'd4:    alt_slot = 3'd1;
      3'd5:    alt_slot = 3'd2;
      3'd6:    alt_slot = 3'd3;
      3'd7:    alt_slot = 3'd4;
      default: alt_slot = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter bit IS_WR = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  input  logic          dlab_i,
  input  logic          alt_i,
  input  logic          ext_en_i,
  input  logic          idx_en_i,
  output tgt_e          tgt_o
);
  always_comb begin
    tgt_o = T_NONE;
    if (dlab_i && addr_i == 3'd0)      tgt_o = T_DLL;
    else if (dlab_i && addr_i == 3'd1) tgt_o = T_DLM;
    else if (addr_i == 3'd3)           tgt_o = T_LCR;
    else if (alt_i)                    tgt_o = T_ALT;
    else begin
      case (addr_i)
        3'd0:    tgt_o = T_HOLD;
        3'd1:    tgt_o = T_IER;
        3'd2:    tgt_o = T_ISR_FCR;
        3'd4:    tgt_o = T_MCR;
        3'd5:    tgt_o = (IS_WR || idx_en_i) ? T_ICR : T_LSR;
        3'd6:    tgt_o = ext_en_i ? T_EXT : T_MSR;
        3'd7:    tgt_o = T_SPR;
        default: tgt_o = T_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rb_idx.sv
module uart_rb_idx
  import uart_rb_pkg::*;
#(
  parameter int unsigned N_IDX = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] acr_o
);
  logic [DW-1:0] regs_q [N_IDX];
  logic [N_IDX-1:0] hit;

  for (genvar i = 0; i < N_IDX; i++) begin : g_reg
    localparam logic [DW-1:0] IDX = DW'(i);
    assign hit[i] = (idx_i == IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_q[i] <= '0;
      else if (we_i && hit[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_IDX; i++)
      if (hit[i]) rdata_o = regs_q[i];
  end

  assign acr_o = regs_q[0];
endmodule

// File: rtl/uart_rb_strobe.sv
module uart_rb_strobe
  import uart_rb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_req_i,
  input  logic          push_req_i,
  input  logic          fcr_req_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rx_pop_o,
  output logic          tx_push_o,
  output logic          fcr_wr_o,
  output logic [DW-1:0] wr_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_pop_o  <= 1'b0;
      tx_push_o <= 1'b0;
      fcr_wr_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      rx_pop_o  <= pop_req_i;
      tx_push_o <= push_req_i;
      fcr_wr_o  <= fcr_req_i;
      if (push_req_i || fcr_req_i) wr_data_o <= wdata_i;
    end
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int unsigned   N_IDX   = 4,
  parameter logic [15:0]   DIV_RST = 16'h0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] lsr_i,
  input  logic [DW-1:0] msr_i,
  output logic [15:0]   divisor_o,
  output logic          dlab_o,
  output logic [1:0]    word_len_o,
  output logic          stop2_o,
  output logic          par_en_o,
  output logic          par_even_o,
  output logic          force_par_o,
  output logic          brk_o,
  output logic [IER_W-1:0] ier_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          loop_o,
  output logic          rx_pop_o,
  output logic          tx_push_o,
  output logic          fcr_wr_o,
  output logic [DW-1:0] wr_data_o
);
  logic [DW-1:0]    dll_q, dlm_q, lcr_q, spr_q, ext_q;
  logic             alt_q;
  logic [IER_W-1:0] ier_q;
  logic [MCR_W-1:0] mcr_q;
  logic [DW-1:0]    alt_bank_q [ALT_N];
  logic [DW-1:0]    acr, icr_rdata;
  tgt_e             tgt [2];  // 0: read path, 1: write path
  tgt_e             rtgt, wtgt;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    uart_rb_decode #(.IS_WR(g == 1)) u_dec (
      .addr_i  (addr_i),
      .dlab_i  (lcr_q[7]),
      .alt_i   (alt_q),
      .ext_en_i(acr[7]),
      .idx_en_i(acr[6]),
      .tgt_o   (tgt[g])
    );
  end
  assign rtgt = tgt[0];
  assign wtgt = tgt[1];

  uart_rb_idx #(.N_IDX(N_IDX)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && wtgt == T_ICR),
    .idx_i  (spr_q),
    .wdata_i(wdata_i),
    .rdata_o(icr_rdata),
    .acr_o  (acr)
  );

  uart_rb_strobe u_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_req_i (rd_i && rtgt == T_HOLD),
    .push_req_i(wr_i && wtgt == T_HOLD),
    .fcr_req_i (wr_i && wtgt == T_ISR_FCR),
    .wdata_i   (wdata_i),
    .rx_pop_o  (rx_pop_o),
    .tx_push_o (tx_push_o),
    .fcr_wr_o  (fcr_wr_o),
    .wr_data_o (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q <= DIV_RST[7:0];
      dlm_q <= DIV_RST[15:8];
      lcr_q <= '0;
      alt_q <= 1'b0;
      ier_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
      ext_q <= '0;
      for (int i = 0; i < ALT_N; i++) alt_bank_q[i] <= '0;
    end else if (wr_i) begin
      case (wtgt)
        T_DLL: dll_q <= wdata_i;
        T_DLM: dlm_q <= wdata_i;
        T_LCR: begin
          if (wdata_i == LCR_KEY) begin
            lcr_q <= {1'b1, lcr_q[6:0]};  // format bits untouched
            alt_q <= 1'b1;
          end else begin
            lcr_q <= wdata_i;
            alt_q <= 1'b0;
          end
        end
        T_IER: ier_q <= wdata_i[IER_W-1:0];
        T_MCR: mcr_q <= wdata_i[MCR_W-1:0];
        T_SPR: spr_q <= wdata_i;
        T_EXT: ext_q <= wdata_i;
        T_ALT: alt_bank_q[alt_slot(addr_i)] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rtgt)
      T_HOLD:    rdata_o = rx_data_i;
      T_DLL:     rdata_o = dll_q;
      T_DLM:     rdata_o = dlm_q;
      T_IER:     rdata_o = DW'(ier_q);
      T_ISR_FCR: rdata_o = isr_i;
      T_LCR:     rdata_o = lcr_q;
      T_MCR:     rdata_o = DW'(mcr_q);
      T_LSR:     rdata_o = lsr_i;
      T_MSR:     rdata_o = msr_i;
      T_SPR:     rdata_o = spr_q;
      T_EXT:     rdata_o = ext_q;
      T_ALT:     rdata_o = alt_bank_q[alt_slot(addr_i)];
      T_ICR:     rdata_o = icr_rdata;
      default:   rdata_o = '0;
    endcase
  end

  assign divisor_o   = {dlm_q, dll_q};
  assign word_len_o  = lcr_q[1:0];
  assign stop2_o     = lcr_q[2];
  assign par_en_o    = lcr_q[3];
  assign par_even_o  = lcr_q[4];
  assign force_par_o = lcr_q[5];
  assign brk_o       = lcr_q[6];
  assign dlab_o      = lcr_q[7];
  assign ier_o       = ier_q;
  assign dtr_o       = mcr_q[0];
  assign rts_o       = mcr_q[1];
  assign out1_o      = mcr_q[2];
  assign out2_o      = mcr_q[3];
  assign loop_o      = mcr_q[4];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_rb_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [15:0]   divisor_o,
  input logic          dlab_o,
  input logic [1:0]    word_len_o,
  input logic          stop2_o,
  input logic          par_en_o,
  input logic          par_even_o,
  input logic          force_par_o,
  input logic          brk_o,
  input logic          rx_pop_o,
  input logic          tx_push_o,
  input logic          fcr_wr_o
);
  p_pop_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> $past(rd_i && addr_i == 3'd0 && !dlab_o));

  p_push_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(wr_i && addr_i == 3'd0 && !dlab_o));

  p_wr_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_push_o, fcr_wr_o}));

  p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && dlab_o && addr_i[2:1] == 2'b00) |=> $stable(divisor_o));

  p_key_keeps_fmt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd3 && wdata_i == LCR_KEY) |=>
      (dlab_o && $stable({brk_o, force_par_o, par_even_o, par_en_o, stop2_o, word_len_o})));

  p_ier_hi_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd1 && !dlab_o) |-> rdata_o[7:4] == 4'h0);
endmodule

bind uart_regbank uart_regbank_chk u_chk (.*);

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IDX = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] rx_data_i = 8'h5C, isr_i = 8'hC1, lsr_i = 8'h60, msr_i = 8'hB0;
  logic [15:0] divisor_o;
  logic dlab_o, stop2_o, par_en_o, par_even_o, force_par_o, brk_o;
  logic [1:0] word_len_o;
  logic [3:0] ier_o;
  logic dtr_o, rts_o, out1_o, out2_o, loop_o;
  logic rx_pop_o, tx_push_o, fcr_wr_o;
  logic [7:0] wr_data_o;

  int n_chk = 0, n_fail = 0;
  logic pop_s, push_s, fcr_s;
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_regbank #(.N_IDX(N_IDX)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk_i); addr_i = a; wdata_i = v; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
    push_s = tx_push_o; fcr_s = fcr_wr_o;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
    pop_s = rx_pop_o;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R7 reset state
    chk("R7 divisor", divisor_o, 16'h0001);
    chk("R7 lcr", {brk_o, force_par_o, par_even_o, par_en_o, stop2_o, word_len_o, dlab_o}, 0);
    chk("R7 ier", ier_o, 0);
    chk("R7 mcr", {loop_o, out2_o, out1_o, rts_o, dtr_o}, 0);
    rd(3'd7, d); chk("R7 spr", d, 0);

    // R1 every non-key line control value
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hBF) continue;
      wr(3'd3, 8'(v));
      chk("R1 fields", {dlab_o, brk_o, force_par_o, par_even_o, par_en_o, stop2_o, word_len_o}, v);
      rd(3'd3, d); chk("R1 readback", d, v);
    end

    // R3 divisor sweep
    wr(3'd3, 8'h80);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] lo, hi;
      lo = 8'(k * 17); hi = 8'(255 - k * 13);
      wr(3'd0, lo); chk("R5 no push on divisor", push_s, 0);
      wr(3'd1, hi);
      chk("R3 divisor", divisor_o, {hi, lo});
      rd(3'd0, d); chk("R3 low", d, lo); chk("R5 no pop on divisor", pop_s, 0);
      rd(3'd1, d); chk("R3 high", d, hi);
    end

    // R4 standard map
    wr(3'd3, 8'h03);
    rd(3'd0, d); chk("R4 rx data", d, rx_data_i);
    chk("R5 pop pulse", pop_s, 1);
    @(negedge clk_i); chk("R5 pop one cycle", rx_pop_o, 0);
    rd(3'd2, d); chk("R4 isr", d, isr_i);
    rd(3'd5, d); chk("R8 lsr", d, lsr_i);
    rd(3'd6, d); chk("R4 msr", d, msr_i);
    for (int v = 0; v < 256; v += 37) begin
      wr(3'd7, 8'(v)); rd(3'd7, d); chk("R4 scratch", d, v);
    end

    // R6 masks
    wr(3'd1, 8'hFF); chk("R6 ier", ier_o, 4'hF);
    rd(3'd1, d); chk("R6 ier read", d, 8'h0F);
    for (int v = 0; v < 64; v++) begin
      wr(3'd4, 8'(v | 8'hC0));
      chk("R6 mcr pins", {loop_o, out2_o, out1_o, rts_o, dtr_o}, v & 5'h1F);
      rd(3'd4, d); chk("R6 mcr read", d, v & 8'h1F);
    end
    wr(3'd4, 8'h15);

    // R5 push, R11 FIFO control
    wr(3'd0, 8'h5A);
    chk("R5 push", push_s, 1); chk("R5 push data", wr_data_o, 8'h5A); chk("R11 no fcr", fcr_s, 0);
    @(negedge clk_i); chk("R5 push one cycle", tx_push_o, 0);
    wr(3'd2, 8'hC7);
    chk("R11 fcr", fcr_s, 1); chk("R11 fcr data", wr_data_o, 8'hC7); chk("R11 no push", push_s, 0);

    // R8 ignored status write, R10 extended
    wr(3'd6, 8'hAA);
    rd(3'd6, d); chk("R8 msr after write", d, msr_i);
    wr(3'd7, 8'h00); wr(3'd5, 8'h80);
    rd(3'd5, d); chk("R8 lsr idx off", d, lsr_i);
    rd(3'd6, d); chk("R8 ext untouched", d, 8'h00);
    wr(3'd6, 8'h3C); rd(3'd6, d); chk("R10 ext", d, 8'h3C);

    // R9 indexed
    wr(3'd5, 8'hC0);
    rd(3'd5, d); chk("R9 acr read", d, 8'hC0);
    for (int i = 1; i <= N_IDX; i++) begin
      wr(3'd7, 8'(i)); wr(3'd5, 8'(8'h10 + i));
      rd(3'd5, d); chk("R9 indexed", d, (i < N_IDX) ? 8'(8'h10 + i) : 8'h00);
    end
    wr(3'd7, 8'h00); wr(3'd5, 8'h00);
    rd(3'd6, d); chk("R10 ext off", d, msr_i);

    // R2 key bank
    wr(3'd3, 8'h1B); wr(3'd3, 8'hBF);
    chk("R2 fmt kept", {dlab_o, brk_o, force_par_o, par_even_o, par_en_o, stop2_o, word_len_o}, 8'h9B);
    rd(3'd3, d); chk("R2 lcr read", d, 8'h9B);
    for (int a = 2; a < 8; a++) if (a != 3) wr(3'(a), 8'(8'hA0 + a));
    for (int a = 2; a < 8; a++) if (a != 3) begin
      rd(3'(a), d); chk("R2 alt", d, 8'(8'hA0 + a));
    end
    chk("R2 mcr kept", {loop_o, out2_o, out1_o, rts_o, dtr_o}, 5'h15);
    wr(3'd0, 8'h33); chk("R3 divisor in alt", divisor_o[7:0], 8'h33);
    wr(3'd3, 8'h03);
    chk("R2 exit", {dlab_o, word_len_o}, 3'b011);
    rd(3'd2, d); chk("R2 isr after exit", d, isr_i);
    rd(3'd4, d); chk("R2 mcr after exit", d, 8'h15);
    rd(3'd7, d); chk("R2 spr after exit", d, 8'h00);
    wr(3'd3, 8'hBF);
    rd(3'd2, d); chk("R2 alt retained", d, 8'hA2);
    rd(3'd7, d); chk("R2 alt retained", d, 8'hA7);

    summary();
  end
endmodule